// File: doc/BRIEF.md
# Serial Frame Offset Meter

The block measures, under processor control, how many system-clock cycles separate the master frame pulse from a frame pulse picked off one serial stream. A selector outside the block routes the chosen per-stream pulse onto the evaluation input. The processor drives a single start bit. Before it raises the bit, it must hold the bit low for at least one whole frame. The rising edge then begins a measurement. After two master frame boundaries the block raises a completion flag and presents a 12-bit offset.

A measurement has four phases. It waits for the next master frame boundary, which opens a one-frame window. It counts clock edges inside the window and latches the count at the first edge where the evaluation input is seen high. The next boundary closes the window, and the block publishes either the latched count or the all-ones code 0xFFF when no pulse arrived. The flag and the value then hold until the processor drops the start bit. Dropping the start bit clears the flag and arms the block for the next measurement.

Top module: `frame_offset_meter`

## Requirements
- R1: After reset, `meas_done` is 0 and `meas_offset` is 0.
- R2: A rise of `start_meas` starts a measurement only when `start_meas` was sampled low on at least FRAME_LEN consecutive clock edges just before the rise. A rise with less low time is ignored: `meas_done` stays 0 and `meas_offset` keeps its value.
- R3: A frame boundary is any clock edge that samples `master_fp` high. The window opens at the first boundary after the accepted rise and closes at the next boundary. `meas_done` goes to 1 in the cycle after the closing edge and is 0 before it.
- R4: `meas_offset` equals the number of clock edges from the opening boundary edge to the edge that first samples `eval_fp` high. It is 0 when both happen on the same edge. Later pulses within the window are ignored.
- R5: If `eval_fp` is never sampled high from the opening edge up to the edge before the closing edge, `meas_offset` becomes 12'hFFF and `meas_done` still goes to 1.
- R6: While `start_meas` stays high after completion, `meas_done` and `meas_offset` do not change, whatever `master_fp` and `eval_fp` do.
- R7: Sampling `start_meas` low clears `meas_done` in the following cycle, and `meas_offset` keeps its value.
- R8: Dropping `start_meas` before completion cancels the measurement. `meas_offset` keeps its previous value, and the rise that follows is ignored unless the low time satisfies R2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| master_fp | input | 1 | Master frame pulse, active high |
| eval_fp | input | 1 | Selected stream frame pulse, active high |
| start_meas | input | 1 | Processor start bit |
| meas_done | output | 1 | Completion flag |
| meas_offset | output | OFS_W (12) | Measured offset, or 12'hFFF when no pulse arrived |

## Verification
The bench drives its own master pulse train, so it always knows which edge will be a boundary. The offset pulse is placed on the k-th negative edge after the one that precedes the opening boundary, which makes the expected offset exactly k. `meas_done` is first sampled at the negative edge just before the closing boundary, where it must still be 0. It is sampled again one negative edge later, after the closing edge, where the flag and the offset must both be valid. The clear is checked one negative edge after the edge that samples `start_meas` low. Ignored and cancelled starts are judged after three full frames, which is longer than any accepted measurement could take.

// File: rtl/fom_pkg.sv
package fom_pkg;
    typedef enum logic [1:0] {
        ST_IDLE      = 2'd0,
        ST_WAIT_OPEN = 2'd1,
        ST_WINDOW    = 2'd2,
        ST_DONE      = 2'd3
    } fom_state_e;
endpackage

// File: rtl/fom_arm.sv
// Tracks how long the start bit has been low; grants a start on a rise
// only when the low time covered a full frame.
module fom_arm #(
    parameter int FRAME_LEN = 2048
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    output logic go_o
);
    localparam int LW = $clog2(FRAME_LEN + 1);
    localparam logic [LW-1:0] ARM_LIMIT = LW'(FRAME_LEN);

    typedef struct packed {
        logic [LW-1:0] low_cnt;
    } arm_reg_t;

    arm_reg_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (start_i) begin
            r_d.low_cnt = '0;
        end else if (r_q.low_cnt != ARM_LIMIT) begin
            r_d.low_cnt = r_q.low_cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign go_o = start_i && (r_q.low_cnt == ARM_LIMIT);

    AST_GO_AFTER_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        go_o |-> $past(!start_i)); // R2
endmodule

// File: rtl/fom_seq.sv
// Frame-boundary sequencer: wait for opening boundary, run the window,
// hold the result until the start bit drops.
module fom_seq
    import fom_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic go_i,
    input  logic start_i,
    input  logic boundary_i,
    output logic open_o,
    output logic in_window_o,
    output logic close_o,
    output logic done_o
);
    typedef struct packed {
        fom_state_e state;
    } seq_reg_t;

    seq_reg_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        unique case (r_q.state)
            ST_IDLE: begin
                if (go_i) r_d.state = ST_WAIT_OPEN;
            end
            ST_WAIT_OPEN: begin
                if (!start_i)        r_d.state = ST_IDLE;
                else if (boundary_i) r_d.state = ST_WINDOW;
            end
            ST_WINDOW: begin
                if (!start_i)        r_d.state = ST_IDLE;
                else if (boundary_i) r_d.state = ST_DONE;
            end
            ST_DONE: begin
                if (!start_i) r_d.state = ST_IDLE;
            end
            default: r_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '{state: ST_IDLE};
        else        r_q <= r_d;
    end

    assign open_o      = (r_q.state == ST_WAIT_OPEN) && start_i && boundary_i;
    assign close_o     = (r_q.state == ST_WINDOW) && start_i && boundary_i;
    assign in_window_o = (r_q.state == ST_WINDOW);
    assign done_o      = (r_q.state == ST_DONE);

    AST_DONE_AFTER_CLOSE: assert property (@(posedge clk) disable iff (!rst_n)
        close_o |=> done_o); // R3
    AST_FLAG_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !start_i) |=> !done_o); // R7
    AST_NO_EARLY_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done_o) |-> $past(in_window_o)); // R3
endmodule

// File: rtl/fom_count.sv
// Window counter, first-pulse capture and result register.
module fom_count #(
    parameter int FRAME_LEN = 2048,
    parameter int OFS_W     = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             open_i,
    input  logic             in_window_i,
    input  logic             close_i,
    input  logic             eval_i,
    output logic [OFS_W-1:0] result_o
);
    localparam logic [OFS_W-1:0] NO_HIT   = '1;
    localparam logic [OFS_W-1:0] FRAME_CW = OFS_W'(FRAME_LEN);

    typedef struct packed {
        logic [OFS_W-1:0] cnt;
        logic             hit;
        logic [OFS_W-1:0] cap;
        logic [OFS_W-1:0] result;
    } cnt_reg_t;

    cnt_reg_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (open_i) begin
            r_d.cnt = OFS_W'(1);
            r_d.hit = eval_i;
            r_d.cap = '0;
        end else if (close_i) begin
            r_d.result = r_q.hit ? r_q.cap : NO_HIT;
        end else if (in_window_i) begin
            r_d.cnt = r_q.cnt + 1'b1;
            if (eval_i && !r_q.hit) begin
                r_d.hit = 1'b1;
                r_d.cap = r_q.cnt;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign result_o = r_q.result;

    AST_CNT_IN_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
        (in_window_i && !close_i) |-> (r_q.cnt != '0 && r_q.cnt < FRAME_CW)); // R4
    AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !close_i |=> $stable(result_o)); // R6
endmodule

// File: rtl/frame_offset_meter.sv
module frame_offset_meter #(
    parameter int FRAME_LEN = 2048,
    parameter int OFS_W     = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             master_fp,
    input  logic             eval_fp,
    input  logic             start_meas,
    output logic             meas_done,
    output logic [OFS_W-1:0] meas_offset
);
    logic go, win_open, in_window, win_close;

    fom_arm #(.FRAME_LEN(FRAME_LEN)) u_arm (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (start_meas),
        .go_o    (go)
    );

    fom_seq u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .go_i        (go),
        .start_i     (start_meas),
        .boundary_i  (master_fp),
        .open_o      (win_open),
        .in_window_o (in_window),
        .close_o     (win_close),
        .done_o      (meas_done)
    );

    fom_count #(.FRAME_LEN(FRAME_LEN), .OFS_W(OFS_W)) u_cnt (
        .clk         (clk),
        .rst_n       (rst_n),
        .open_i      (win_open),
        .in_window_i (in_window),
        .close_i     (win_close),
        .eval_i      (eval_fp),
        .result_o    (meas_offset)
    );

    AST_CANCEL_KEEPS_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
        (!meas_done && !start_meas) |=> $stable(meas_offset)); // R8
endmodule

// File: tb/frame_offset_meter_tb.sv
module frame_offset_meter_tb;
    localparam int FL = 256;
    localparam int OW = 12;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic master_fp = 1'b0;
    logic eval_fp = 1'b0;
    logic start_meas = 1'b0;
    logic meas_done;
    logic [OW-1:0] meas_offset;

    int n_chk = 0;
    int n_fail = 0;
    int phase = 0;
    int last_ofs = 0;

    always #4 clk = ~clk;

    frame_offset_meter #(.FRAME_LEN(FL), .OFS_W(OW)) u_dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .master_fp   (master_fp),
        .eval_fp     (eval_fp),
        .start_meas  (start_meas),
        .meas_done   (meas_done),
        .meas_offset (meas_offset)
    );

    function automatic int exp_offset(int k);
        return (k < 0) ? 32'hFFF : k;
    endfunction

    task automatic check(string req, int act, int exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // master pulse train: one high cycle per FL cycles
    initial begin
        forever begin
            @(negedge clk);
            phase = (phase + 1) % FL;
            master_fp = (phase == 0);
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    // ends at the negedge just before a boundary edge
    task automatic to_pre_boundary();
        do @(negedge clk); while (!master_fp);
    endtask

    task automatic arm_and_start();
        start_meas = 1'b0;
        repeat (FL + 3) @(negedge clk);
        to_pre_boundary();
        @(negedge clk);
        start_meas = 1'b1;
    endtask

    task automatic measure(int k, int k2, string tag);
        int e;
        e = exp_offset(k);
        arm_and_start();
        to_pre_boundary();
        for (int i = 0; i < FL; i++) begin
            eval_fp = (i == k) || (i == k2);
            @(negedge clk);
        end
        eval_fp = 1'b0;
        check({tag, " R3 flag low before close"}, int'(meas_done), 0);
        @(negedge clk);
        check({tag, " R3 flag after close"}, int'(meas_done), 1);
        check({tag, (k < 0) ? " R5 no pulse" : " R4 offset"}, int'(meas_offset), e);
        for (int i = 0; i < FL + 5; i++) begin
            eval_fp = (i == 7);
            @(negedge clk);
        end
        eval_fp = 1'b0;
        check({tag, " R6 flag held"}, int'(meas_done), 1);
        check({tag, " R6 offset held"}, int'(meas_offset), e);
        start_meas = 1'b0;
        @(negedge clk);
        check({tag, " R7 flag cleared"}, int'(meas_done), 0);
        check({tag, " R7 offset kept"}, int'(meas_offset), e);
        last_ofs = e;
    endtask

    task automatic rise_after_low(int low_cycles, int pulse_at);
        start_meas = 1'b1;
        repeat (3) @(negedge clk);
        start_meas = 1'b0;
        repeat (low_cycles) @(negedge clk);
        start_meas = 1'b1;
        for (int i = 0; i < 3 * FL + 4; i++) begin
            eval_fp = (i == pulse_at);
            @(negedge clk);
        end
        eval_fp = 1'b0;
    endtask

    initial begin
        int k, k2;
        void'($urandom(32'h5EED));
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 reset flag", int'(meas_done), 0);
        check("R1 reset offset", int'(meas_offset), 0);

        measure(0, -1, "zero");
        measure(FL - 1, -1, "max");
        measure(-1, -1, "none");
        measure(5, 40, "first_wins");
        measure(1, 2, "one");

        // R2: one cycle short of a frame low -> ignored
        rise_after_low(FL - 1, 300);
        check("R2 short low ignored flag", int'(meas_done), 0);
        check("R2 short low ignored offset", int'(meas_offset), last_ofs);
        start_meas = 1'b0;
        @(negedge clk);

        // R2: exactly a frame low -> accepted, no pulse -> R5 sentinel
        rise_after_low(FL, -1);
        check("R2 exact low accepted", int'(meas_done), 1);
        check("R5 exact low no pulse", int'(meas_offset), 32'hFFF);
        start_meas = 1'b0;
        @(negedge clk);
        last_ofs = 32'hFFF;

        measure(77, -1, "before_abort");

        // R8: cancel mid-window, immediate re-rise is unarmed
        arm_and_start();
        to_pre_boundary();
        for (int i = 0; i < 10; i++) begin
            eval_fp = (i == 3);
            @(negedge clk);
        end
        eval_fp = 1'b0;
        start_meas = 1'b0;
        @(negedge clk);
        start_meas = 1'b1;
        repeat (3 * FL + 4) @(negedge clk);
        check("R8 cancel flag", int'(meas_done), 0);
        check("R8 cancel offset", int'(meas_offset), last_ofs);
        start_meas = 1'b0;
        @(negedge clk);

        for (int t = 0; t < 8; t++) begin
            k = int'($urandom_range(FL - 1, 0));
            if ($urandom_range(4, 0) == 0) k = -1;
            k2 = (k >= 0 && k < FL - 2) ? int'($urandom_range(FL - 1, k + 1)) : -1;
            measure(k, k2, "random");
        end

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule